// File: doc/BRIEF.md
# Security-Filtered Interrupt Distributor Register Bank

This block is the byte-wide register file of an interrupt distributor for a small, parameterised set of interrupt lines. It keeps, for every line, a group bit, an enable bit, pending and active state, a two-bit trigger configuration and, for shared lines, a target CPU mask. For every CPU it also keeps an 8-bit source mask per software-generated interrupt (SGI), and the pending bit of that SGI follows from its mask. Lines numbered below `NUM_INTERNAL` are private to each CPU. Lines at or above that number are shared.

Every access arrives on a single request port. The port carries a valid strobe, a write flag, a byte address, a write byte, the number of the accessing CPU and a secure attribute. A chip-level `sec_ext_en` input turns the security filter on. With the filter on, a non-secure access can only see and change the bits of group-1 lines. The bits of group-0 lines in the same byte read as zero, and writes to them are dropped.

Top module: `secure_irq_dist_regs`

## Requirements
- R1: A read request returns `rd_valid`=1, with its data on `rd_data`, exactly one cycle later. A write request gives `rd_valid`=0 in that cycle, and the written state is visible to a read issued in the following cycle. After reset `rd_valid` is 0.
- R2: Group bytes sit at 0x080+k, where bit i is line 8k+i and 1 means group 1. Reset value is 0. A non-secure access with the filter on reads 0x00 from a group byte and cannot change it.
- R3: Enable-set bytes sit at 0x100+k and enable-clear bytes at 0x180+k (bit i is line 8k+i). Writing 1 to a bit sets or clears that enable. Writing 0 leaves it unchanged. Both bytes read back the current enables.
- R4: Pending-set bytes sit at 0x200+k and pending-clear bytes at 0x280+k. For a private line, set and clear act on the accessing CPU only. For a shared line, set marks it pending for every CPU in its target mask, and clear removes it for all CPUs. A read of a shared line returns the OR over all CPUs.
- R5: Active-set bytes sit at 0x300+k and active-clear bytes at 0x380+k. They follow the same private/shared rules as R4.
- R6: Lines below `NUM_INTERNAL` have a separate group, enable, pending and active bit per CPU. A change made by one CPU is not seen by another. A write to a shared group or enable bit updates the copy of every CPU.
- R7: Target bytes sit at 0x800+n, one per line, with bit k meaning CPU k. A shared line reads back the written mask. A private line reads as a one-hot byte with the accessing CPU's bit set, and writes to it are ignored.
- R8: Configuration bytes sit at 0xC00+k and cover lines 4k..4k+3, two bits each at bits 2j+1:2j. Bit 2j+1 set means edge-triggered. For SGI lines (below `NUM_SGI`) every write is ORed with 0xAA, and those lines reset to binary 10. All other lines reset to 00.
- R9: A write to 0xF20+s ORs the byte into SGI s's source mask for the accessing CPU and sets that SGI's pending bit for that CPU. A read of 0xF20+s returns the mask.
- R10: A write to 0xF10+s clears the written source bits. If the mask becomes zero in that write, the SGI's pending bit for the accessing CPU is cleared in the same cycle. A read of 0xF10+s returns the mask.
- R11: With the filter on, a non-secure access to a line whose group bit (for the accessing CPU) is 0 reads that line's bits as 0 and leaves its state unchanged. This covers R3–R5, R7–R10, including both SGI operations. Group-1 bits in the same byte are read and written normally.
- R12: A secure access, or any access with `sec_ext_en`=0, sees and modifies every bit.
- R13: Addresses outside the windows above read as 0x00, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sec_ext_en | input | 1 | Enables the non-secure filter |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Secure attribute of the access |
| req_cpu | input | CPU_W | Number of the accessing CPU |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 8 | Read byte |

## Verification
Two functions can land on the same byte in the same cycle: the security filter drops some lanes while the register update lands on the others. The bench provokes this directly. It makes the lower half of a shared byte group 1, writes all ones to that byte non-securely, and expects only the group-1 half to change when it is read back securely and non-securely. A second case of the same kind is an SGI source clear that empties the mask, where the mask and the derived pending bit must both change in that single write. The randomized phase then mixes secure and non-secure traffic, switches the filter on and off, and compares every read against a reference model built from the requirements.

// File: rtl/sidr_pkg.sv
package sidr_pkg;

    localparam logic [11:0] OFS_GROUP  = 12'h080;
    localparam logic [11:0] OFS_ENSET  = 12'h100;
    localparam logic [11:0] OFS_ENCLR  = 12'h180;
    localparam logic [11:0] OFS_PSET   = 12'h200;
    localparam logic [11:0] OFS_PCLR   = 12'h280;
    localparam logic [11:0] OFS_ASET   = 12'h300;
    localparam logic [11:0] OFS_ACLR   = 12'h380;
    localparam logic [11:0] OFS_TARGET = 12'h800;
    localparam logic [11:0] OFS_CFG    = 12'hC00;
    localparam logic [11:0] OFS_SGICLR = 12'hF10;
    localparam logic [11:0] OFS_SGISET = 12'hF20;

    // SGI lines are forced edge-triggered on every configuration write
    localparam logic [1:0] SGI_CFG_FORCE = 2'b10;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_GROUP,
        RG_ENSET,
        RG_ENCLR,
        RG_PSET,
        RG_PCLR,
        RG_ASET,
        RG_ACLR,
        RG_TARGET,
        RG_CFG,
        RG_SGICLR,
        RG_SGISET
    } region_e;

    function automatic logic in_win(logic [11:0] a, logic [11:0] base, int len);
        return (a >= base) && (int'(a - base) < len);
    endfunction

    // regions whose byte lanes map to different interrupt lines
    function automatic logic is_lane_map(region_e r);
        return (r == RG_GROUP) || (r == RG_ENSET) || (r == RG_ENCLR) ||
               (r == RG_PSET)  || (r == RG_PCLR)  || (r == RG_ASET)  ||
               (r == RG_ACLR)  || (r == RG_CFG);
    endfunction

endpackage

// File: rtl/sidr_decode.sv
module sidr_decode
    import sidr_pkg::*;
#(
    parameter int NUM_IRQ      = 64,
    parameter int NUM_INTERNAL = 32,
    parameter int NUM_SGI      = 16,
    parameter int IRQ_W        = 6
) (
    input  logic [11:0]                addr,
    output region_e                    region,
    output logic [7:0][IRQ_W-1:0]      bit_irq,
    output logic [7:0]                 bit_bank
);
    localparam int N_BYTE8 = NUM_IRQ / 8;
    localparam int N_CFG   = NUM_IRQ / 4;

    logic [11:0] off;

    always_comb begin
        region = RG_NONE;
        off    = '0;
        if (in_win(addr, OFS_GROUP, N_BYTE8)) begin
            region = RG_GROUP;  off = addr - OFS_GROUP;
        end else if (in_win(addr, OFS_ENSET, N_BYTE8)) begin
            region = RG_ENSET;  off = addr - OFS_ENSET;
        end else if (in_win(addr, OFS_ENCLR, N_BYTE8)) begin
            region = RG_ENCLR;  off = addr - OFS_ENCLR;
        end else if (in_win(addr, OFS_PSET, N_BYTE8)) begin
            region = RG_PSET;   off = addr - OFS_PSET;
        end else if (in_win(addr, OFS_PCLR, N_BYTE8)) begin
            region = RG_PCLR;   off = addr - OFS_PCLR;
        end else if (in_win(addr, OFS_ASET, N_BYTE8)) begin
            region = RG_ASET;   off = addr - OFS_ASET;
        end else if (in_win(addr, OFS_ACLR, N_BYTE8)) begin
            region = RG_ACLR;   off = addr - OFS_ACLR;
        end else if (in_win(addr, OFS_TARGET, NUM_IRQ)) begin
            region = RG_TARGET; off = addr - OFS_TARGET;
        end else if (in_win(addr, OFS_CFG, N_CFG)) begin
            region = RG_CFG;    off = addr - OFS_CFG;
        end else if (in_win(addr, OFS_SGICLR, NUM_SGI)) begin
            region = RG_SGICLR; off = addr - OFS_SGICLR;
        end else if (in_win(addr, OFS_SGISET, NUM_SGI)) begin
            region = RG_SGISET; off = addr - OFS_SGISET;
        end
    end

    // map every data bit to the interrupt line it belongs to
    always_comb begin
        for (int b = 0; b < 8; b++) begin
            if (region == RG_NONE) begin
                bit_irq[b] = '0;
            end else if (region == RG_CFG) begin
                bit_irq[b] = IRQ_W'({off[7:0], 2'b00}) + IRQ_W'(b / 2);
            end else if (is_lane_map(region)) begin
                bit_irq[b] = IRQ_W'({off[7:0], 3'b000}) + IRQ_W'(b);
            end else begin
                bit_irq[b] = IRQ_W'(off[7:0]);
            end
            bit_bank[b] = int'(bit_irq[b]) < NUM_INTERNAL;
        end
    end

endmodule

// File: rtl/sidr_filter.sv
module sidr_filter
    import sidr_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int IRQ_W   = 6
) (
    input  region_e                 region,
    input  logic [7:0][IRQ_W-1:0]   bit_irq,
    input  logic [NUM_IRQ-1:0]      grp_row,
    input  logic                    sec_ext_en,
    input  logic                    req_secure,
    output logic [7:0]              acc_mask
);
    logic                 priv;
    logic [NUM_IRQ-1:0]   visible;

    assign priv    = !sec_ext_en || req_secure;
    assign visible = {NUM_IRQ{priv}} | grp_row;

    always_comb begin
        acc_mask = '0;
        if (region == RG_GROUP) begin
            acc_mask = {8{priv}};
        end else if (region != RG_NONE) begin
            for (int b = 0; b < 8; b++) begin
                acc_mask[b] = visible[bit_irq[b]];
            end
        end
    end

endmodule

// File: rtl/sidr_state.sv
module sidr_state
    import sidr_pkg::*;
#(
    parameter int NUM_CPU      = 2,
    parameter int NUM_IRQ      = 64,
    parameter int NUM_SGI      = 16,
    parameter int CPU_W        = 1,
    parameter int IRQ_W        = 6,
    parameter int SGI_W        = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [CPU_W-1:0]        req_cpu,
    input  logic [7:0]              wdata,
    input  region_e                 region,
    input  logic [7:0][IRQ_W-1:0]   bit_irq,
    input  logic [7:0]              bit_bank,
    input  logic [7:0]              acc_mask,
    output logic [NUM_IRQ-1:0]      grp_row,
    output logic [7:0]              rd_byte
);
    logic [NUM_IRQ-1:0] grp_q  [NUM_CPU];
    logic [NUM_IRQ-1:0] en_q   [NUM_CPU];
    logic [NUM_IRQ-1:0] pend_q [NUM_CPU];
    logic [NUM_IRQ-1:0] act_q  [NUM_CPU];
    logic [NUM_CPU-1:0] tgt_q  [NUM_IRQ];
    logic [1:0]         cfg_q  [NUM_IRQ];
    logic [7:0]         src_q  [NUM_CPU][NUM_SGI];

    logic [SGI_W-1:0]   sgi_idx;
    logic [7:0]         sgi_left;
    logic [7:0]         wset;
    logic               do_wr;

    assign sgi_idx  = SGI_W'(bit_irq[0]);
    assign sgi_left = src_q[req_cpu][sgi_idx] & ~wdata;
    assign wset     = wdata & acc_mask;
    assign do_wr    = req_valid && req_write;
    assign grp_row  = grp_q[req_cpu];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NUM_CPU; k++) begin
                grp_q[k]  <= '0;
                en_q[k]   <= '0;
                pend_q[k] <= '0;
                act_q[k]  <= '0;
                for (int s = 0; s < NUM_SGI; s++) src_q[k][s] <= '0;
            end
            for (int n = 0; n < NUM_IRQ; n++) begin
                tgt_q[n] <= '0;
                cfg_q[n] <= (n < NUM_SGI) ? SGI_CFG_FORCE : 2'b00;
            end
        end else if (do_wr) begin
            case (region)
                RG_GROUP: begin
                    for (int b = 0; b < 8; b++) begin
                        if (acc_mask[b]) begin
                            if (bit_bank[b]) grp_q[req_cpu][bit_irq[b]] <= wdata[b];
                            else for (int k = 0; k < NUM_CPU; k++) grp_q[k][bit_irq[b]] <= wdata[b];
                        end
                    end
                end
                RG_ENSET, RG_ENCLR: begin
                    for (int b = 0; b < 8; b++) begin
                        if (wset[b]) begin
                            if (bit_bank[b]) en_q[req_cpu][bit_irq[b]] <= (region == RG_ENSET);
                            else for (int k = 0; k < NUM_CPU; k++) en_q[k][bit_irq[b]] <= (region == RG_ENSET);
                        end
                    end
                end
                RG_PSET, RG_ASET: begin
                    for (int b = 0; b < 8; b++) begin
                        if (wset[b]) begin
                            if (bit_bank[b]) begin
                                if (region == RG_PSET) pend_q[req_cpu][bit_irq[b]] <= 1'b1;
                                else                   act_q[req_cpu][bit_irq[b]]  <= 1'b1;
                            end else begin
                                for (int k = 0; k < NUM_CPU; k++) begin
                                    if (tgt_q[bit_irq[b]][k]) begin
                                        if (region == RG_PSET) pend_q[k][bit_irq[b]] <= 1'b1;
                                        else                   act_q[k][bit_irq[b]]  <= 1'b1;
                                    end
                                end
                            end
                        end
                    end
                end
                RG_PCLR, RG_ACLR: begin
                    for (int b = 0; b < 8; b++) begin
                        if (wset[b]) begin
                            if (bit_bank[b]) begin
                                if (region == RG_PCLR) pend_q[req_cpu][bit_irq[b]] <= 1'b0;
                                else                   act_q[req_cpu][bit_irq[b]]  <= 1'b0;
                            end else begin
                                for (int k = 0; k < NUM_CPU; k++) begin
                                    if (region == RG_PCLR) pend_q[k][bit_irq[b]] <= 1'b0;
                                    else                   act_q[k][bit_irq[b]]  <= 1'b0;
                                end
                            end
                        end
                    end
                end
                RG_TARGET: begin
                    if (acc_mask[0] && !bit_bank[0]) begin
                        for (int k = 0; k < NUM_CPU; k++) tgt_q[bit_irq[0]][k] <= wdata[k];
                    end
                end
                RG_CFG: begin
                    for (int j = 0; j < 4; j++) begin
                        if (acc_mask[2*j]) begin
                            cfg_q[bit_irq[2*j]] <= wdata[2*j +: 2] |
                                ((int'(bit_irq[2*j]) < NUM_SGI) ? SGI_CFG_FORCE : 2'b00);
                        end
                    end
                end
                RG_SGISET: begin
                    if (acc_mask[0]) begin
                        src_q[req_cpu][sgi_idx]       <= src_q[req_cpu][sgi_idx] | wdata;
                        pend_q[req_cpu][bit_irq[0]]   <= 1'b1;
                    end
                end
                RG_SGICLR: begin
                    if (acc_mask[0]) begin
                        src_q[req_cpu][sgi_idx] <= sgi_left;
                        if (sgi_left == '0) pend_q[req_cpu][bit_irq[0]] <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_byte = '0;
        case (region)
            RG_GROUP:
                for (int b = 0; b < 8; b++) rd_byte[b] = grp_q[req_cpu][bit_irq[b]];
            RG_ENSET, RG_ENCLR:
                for (int b = 0; b < 8; b++) rd_byte[b] = en_q[req_cpu][bit_irq[b]];
            RG_PSET, RG_PCLR, RG_ASET, RG_ACLR:
                for (int b = 0; b < 8; b++) begin
                    for (int k = 0; k < NUM_CPU; k++) begin
                        if (!bit_bank[b] || (k == int'(req_cpu))) begin
                            if ((region == RG_PSET) || (region == RG_PCLR))
                                rd_byte[b] = rd_byte[b] | pend_q[k][bit_irq[b]];
                            else
                                rd_byte[b] = rd_byte[b] | act_q[k][bit_irq[b]];
                        end
                    end
                end
            RG_TARGET:
                rd_byte = bit_bank[0] ? (8'(1) << req_cpu) : 8'(tgt_q[bit_irq[0]]);
            RG_CFG:
                for (int j = 0; j < 4; j++) rd_byte[2*j +: 2] = cfg_q[bit_irq[2*j]];
            RG_SGICLR, RG_SGISET:
                rd_byte = src_q[req_cpu][sgi_idx];
            default: rd_byte = '0;
        endcase
    end

endmodule

// File: rtl/secure_irq_dist_regs.sv
module secure_irq_dist_regs
    import sidr_pkg::*;
#(
    parameter  int NUM_CPU      = 2,
    parameter  int NUM_IRQ      = 64,
    parameter  int NUM_INTERNAL = 32,
    parameter  int NUM_SGI      = 16,
    localparam int CPU_W        = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int IRQ_W        = $clog2(NUM_IRQ),
    localparam int SGI_W        = (NUM_SGI > 1) ? $clog2(NUM_SGI) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_ext_en,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_secure,
    input  logic [CPU_W-1:0]  req_cpu,
    input  logic [11:0]       req_addr,
    input  logic [7:0]        req_wdata,
    output logic              rd_valid,
    output logic [7:0]        rd_data
);
    region_e                 region;
    logic [7:0][IRQ_W-1:0]   bit_irq;
    logic [7:0]              bit_bank;
    logic [NUM_IRQ-1:0]      grp_row;
    logic [7:0]              acc_mask;
    logic [7:0]              rd_byte;

    sidr_decode #(
        .NUM_IRQ(NUM_IRQ), .NUM_INTERNAL(NUM_INTERNAL),
        .NUM_SGI(NUM_SGI), .IRQ_W(IRQ_W)
    ) u_dec (
        .addr(req_addr), .region(region), .bit_irq(bit_irq), .bit_bank(bit_bank)
    );

    sidr_filter #(.NUM_IRQ(NUM_IRQ), .IRQ_W(IRQ_W)) u_flt (
        .region(region), .bit_irq(bit_irq), .grp_row(grp_row),
        .sec_ext_en(sec_ext_en), .req_secure(req_secure), .acc_mask(acc_mask)
    );

    sidr_state #(
        .NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ), .NUM_SGI(NUM_SGI),
        .CPU_W(CPU_W), .IRQ_W(IRQ_W), .SGI_W(SGI_W)
    ) u_st (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_cpu(req_cpu), .wdata(req_wdata), .region(region),
        .bit_irq(bit_irq), .bit_bank(bit_bank), .acc_mask(acc_mask),
        .grp_row(grp_row), .rd_byte(rd_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= req_valid && !req_write;
            rd_data  <= (req_valid && !req_write) ? (rd_byte & acc_mask) : 8'h00;
        end
    end

endmodule

// File: rtl/sidr_chk.sv
module sidr_chk
    import sidr_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       sec_ext_en,
    input logic       req_valid,
    input logic       req_write,
    input logic       req_secure,
    input region_e    region,
    input logic [7:0] acc_mask,
    input logic       rd_valid,
    input logic [7:0] rd_data
);
    // R1: every read is answered in the next cycle
    a_r1_read_answered: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rd_valid);

    // R1: no answer without a read in the previous cycle
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> !rd_valid);

    // R11: lanes the filter blocked come back as zero
    a_r11_blocked_lanes_zero: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ((rd_data & ~$past(acc_mask)) == 8'h00));

    // R12: privileged access opens every lane of a bit-mapped byte
    a_r12_privileged_open: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (!sec_ext_en || req_secure) && is_lane_map(region))
            |-> (acc_mask == 8'hFF));

    // R13: unmapped reads return zero
    a_r13_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(region == RG_NONE)) |-> (rd_data == 8'h00));

endmodule

bind secure_irq_dist_regs sidr_chk u_chk (
    .clk(clk), .rst(rst), .sec_ext_en(sec_ext_en), .req_valid(req_valid),
    .req_write(req_write), .req_secure(req_secure), .region(region),
    .acc_mask(acc_mask), .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/secure_irq_dist_regs_test.sv
module secure_irq_dist_regs_test;
    localparam int CLK_P = 10;
    localparam int NCPU  = 2;
    localparam int NIRQ  = 64;
    localparam int NINT  = 32;
    localparam int NSGI  = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sec_ext_en = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_secure = 1'b0;
    logic [0:0]  req_cpu = '0;
    logic [11:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // reference state
    bit       m_grp  [NCPU][NIRQ];
    bit       m_en   [NCPU][NIRQ];
    bit       m_pend [NCPU][NIRQ];
    bit       m_act  [NCPU][NIRQ];
    bit [1:0] m_tgt  [NIRQ];
    bit [1:0] m_cfg  [NIRQ];
    bit [7:0] m_src  [NCPU][NSGI];

    secure_irq_dist_regs uut (
        .clk(clk), .rst(rst), .sec_ext_en(sec_ext_en), .req_valid(req_valid),
        .req_write(req_write), .req_secure(req_secure), .req_cpu(req_cpu),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input bit [7:0] act, input bit [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic string tag_of(int a);
        if (a >= 'h080 && a < 'h088) return "R2";
        if (a >= 'h100 && a < 'h190) return "R3";
        if (a >= 'h200 && a < 'h290) return "R4";
        if (a >= 'h300 && a < 'h390) return "R5";
        if (a >= 'h800 && a < 'h840) return "R7";
        if (a >= 'hC00 && a < 'hC10) return "R8";
        if (a >= 'hF10 && a < 'hF20) return "R10";
        if (a >= 'hF20 && a < 'hF30) return "R9";
        return "R13";
    endfunction

    function automatic bit vis(int c, bit s, int n);
        return !sec_ext_en || s || m_grp[c][n];
    endfunction

    task automatic model_reset();
        for (int k = 0; k < NCPU; k++) begin
            for (int n = 0; n < NIRQ; n++) begin
                m_grp[k][n] = 0; m_en[k][n] = 0; m_pend[k][n] = 0; m_act[k][n] = 0;
            end
            for (int s = 0; s < NSGI; s++) m_src[k][s] = 0;
        end
        for (int n = 0; n < NIRQ; n++) begin
            m_tgt[n] = 0;
            m_cfg[n] = (n < NSGI) ? 2'b10 : 2'b00;
        end
    endtask

    // set (v=1) or clear (v=0) pending (kind 0) or active (kind 1)
    task automatic pa_write(int kind, int c, int n, bit v);
        for (int k = 0; k < NCPU; k++) begin
            if ((n < NINT && k == c) || (n >= NINT && (!v || m_tgt[n][k]))) begin
                if (kind == 0) m_pend[k][n] = v; else m_act[k][n] = v;
            end
        end
    endtask

    task automatic model_op(input bit wr, input int c, input bit s, input int a,
                            input bit [7:0] d, output bit [7:0] e);
        bit priv;
        priv = !sec_ext_en || s;
        e = 8'h00;
        if (a >= 'h080 && a < 'h088) begin
            for (int b = 0; b < 8; b++) begin
                int n;
                n = (a - 'h080) * 8 + b;
                e[b] = priv && m_grp[c][n];
                if (wr && priv)
                    for (int k = 0; k < NCPU; k++)
                        if (n >= NINT || k == c) m_grp[k][n] = d[b];
            end
        end else if (a >= 'h100 && a < 'h390 && ((a & 'h7F) < 8)) begin
            int kind;
            bit setop;
            kind  = (a - 'h100) / 'h100;          // 0 enable, 1 pending, 2 active
            setop = ((a & 'h80) == 0);
            for (int b = 0; b < 8; b++) begin
                int n;
                bit v;
                n = (a & 'h7) * 8 + b;
                v = vis(c, s, n);
                if (kind == 0) e[b] = v && m_en[c][n];
                else begin
                    bit any;
                    any = 0;
                    for (int k = 0; k < NCPU; k++)
                        if (n >= NINT || k == c)
                            any = any | ((kind == 1) ? m_pend[k][n] : m_act[k][n]);
                    e[b] = v && any;
                end
                if (wr && v && d[b]) begin
                    if (kind == 0) begin
                        for (int k = 0; k < NCPU; k++)
                            if (n >= NINT || k == c) m_en[k][n] = setop;
                    end else pa_write(kind - 1, c, n, setop);
                end
            end
        end else if (a >= 'h800 && a < 'h840) begin
            int n;
            n = a - 'h800;
            if (vis(c, s, n)) begin
                e = (n < NINT) ? (8'h01 << c) : {6'b0, m_tgt[n]};
                if (wr && n >= NINT) m_tgt[n] = d[1:0];
            end
        end else if (a >= 'hC00 && a < 'hC10) begin
            for (int j = 0; j < 4; j++) begin
                int n;
                n = (a - 'hC00) * 4 + j;
                if (vis(c, s, n)) begin
                    e[2*j +: 2] = m_cfg[n];
                    if (wr) m_cfg[n] = d[2*j +: 2] | ((n < NSGI) ? 2'b10 : 2'b00);
                end
            end
        end else if (a >= 'hF10 && a < 'hF30) begin
            int n;
            n = a & 'hF;
            if (vis(c, s, n)) begin
                e = m_src[c][n];
                if (wr) begin
                    if (a >= 'hF20) begin
                        m_src[c][n] = m_src[c][n] | d;
                        m_pend[c][n] = 1;
                    end else begin
                        m_src[c][n] = m_src[c][n] & ~d;
                        if (m_src[c][n] == 0) m_pend[c][n] = 0;
                    end
                end
            end
        end
    endtask

    task automatic access(input bit wr, input int c, input bit s, input int a,
                          input bit [7:0] d, output bit [7:0] got);
        bit [7:0] e;
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = wr;
        req_cpu    = c[0:0];
        req_secure = s;
        req_addr   = a[11:0];
        req_wdata  = d;
        model_op(wr, c, s, a, d, e);
        @(negedge clk);
        req_valid = 1'b0;
        got = rd_data;
        chk("R1 rd_valid", {7'b0, rd_valid}, {7'b0, !wr});
        if (!wr) chk(tag_of(a), rd_data, e);
    endtask

    task automatic wr_b(int c, bit s, int a, bit [7:0] d);
        bit [7:0] g;
        access(1'b1, c, s, a, d, g);
    endtask

    task automatic rd_b(int c, bit s, int a, string tag, bit [7:0] exp);
        bit [7:0] g;
        access(1'b0, c, s, a, 8'h00, g);
        chk(tag, g, exp);
    endtask

    function automatic int rand_addr();
        int r;
        r = $urandom_range(0, 12);
        case (r)
            0:  return 'h080 + $urandom_range(0, 7);
            1:  return 'h100 + $urandom_range(0, 7);
            2:  return 'h180 + $urandom_range(0, 7);
            3:  return 'h200 + $urandom_range(0, 7);
            4:  return 'h280 + $urandom_range(0, 7);
            5:  return 'h300 + $urandom_range(0, 7);
            6:  return 'h380 + $urandom_range(0, 7);
            7:  return 'h800 + $urandom_range(0, 63);
            8:  return 'hC00 + $urandom_range(0, 15);
            9:  return 'hF10 + $urandom_range(0, 15);
            10: return 'hF20 + $urandom_range(0, 15);
            11: return 'hF20 + $urandom_range(0, 3);
            default: begin
                int u;
                u = $urandom_range(0, 4);
                return (u == 0) ? 'h000 : (u == 1) ? 'h400 : (u == 2) ? 'hF00 :
                       (u == 3) ? 'hF30 : 'hFFC;
            end
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog expired actual=hang expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240613));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset rd_valid", {7'b0, rd_valid}, 8'h00);

        // reset values
        rd_b(0, 1'b1, 'h080, "R2 reset group", 8'h00);
        rd_b(0, 1'b1, 'hC00, "R8 reset SGI cfg", 8'hAA);
        rd_b(0, 1'b1, 'hC08, "R8 reset shared cfg", 8'h00);

        // mixed-group byte under the filter
        sec_ext_en = 1'b1;
        wr_b(0, 1'b1, 'h084, 8'h0F);
        rd_b(1, 1'b0, 'h084, "R2 group RAZ non-secure", 8'h00);
        wr_b(1, 1'b0, 'h084, 8'hFF);
        rd_b(0, 1'b1, 'h084, "R2 group WI non-secure", 8'h0F);
        wr_b(0, 1'b0, 'h104, 8'hFF);
        rd_b(0, 1'b1, 'h104, "R11 mixed byte write", 8'h0F);
        rd_b(0, 1'b0, 'h104, "R11 mixed byte read", 8'h0F);
        wr_b(0, 1'b1, 'h104, 8'hFF);
        rd_b(0, 1'b0, 'h104, "R11 group0 RAZ", 8'h0F);
        rd_b(0, 1'b1, 'h104, "R12 secure sees all", 8'hFF);
        wr_b(0, 1'b0, 'h184, 8'hFF);
        rd_b(0, 1'b1, 'h104, "R3 clear only group1", 8'hF0);
        sec_ext_en = 1'b0;
        rd_b(0, 1'b0, 'h104, "R12 filter off", 8'hF0);
        sec_ext_en = 1'b1;

        // private lines per CPU
        wr_b(0, 1'b1, 'h100, 8'h01);
        rd_b(1, 1'b1, 'h100, "R6 other CPU copy", 8'h00);
        rd_b(0, 1'b1, 'h100, "R6 own copy", 8'h01);
        rd_b(1, 1'b1, 'h104, "R6 shared enable copy", 8'hF0);

        // SGI source masks
        wr_b(1, 1'b1, 'hF23, 8'h05);
        rd_b(1, 1'b1, 'hF23, "R9 mask", 8'h05);
        rd_b(1, 1'b1, 'h200, "R9 pending set", 8'h08);
        rd_b(0, 1'b1, 'h200, "R6 SGI pending other CPU", 8'h00);
        wr_b(1, 1'b1, 'hF13, 8'h01);
        rd_b(1, 1'b1, 'hF13, "R10 partial clear", 8'h04);
        rd_b(1, 1'b1, 'h200, "R10 still pending", 8'h08);
        wr_b(1, 1'b1, 'hF13, 8'h04);
        rd_b(1, 1'b1, 'h200, "R10 drained", 8'h00);
        wr_b(1, 1'b0, 'hF24, 8'hFF);
        rd_b(1, 1'b1, 'hF24, "R11 SGI set suppressed", 8'h00);
        rd_b(1, 1'b1, 'h200, "R11 SGI pending untouched", 8'h00);

        // targets, shared pending and active
        rd_b(0, 1'b1, 'h805, "R7 private target cpu0", 8'h01);
        rd_b(1, 1'b1, 'h805, "R7 private target cpu1", 8'h02);
        wr_b(0, 1'b1, 'h805, 8'h03);
        rd_b(0, 1'b1, 'h805, "R7 private target write ignored", 8'h01);
        wr_b(0, 1'b1, 'h828, 8'h02);
        rd_b(0, 1'b1, 'h828, "R7 shared target", 8'h02);
        wr_b(0, 1'b1, 'h205, 8'h01);
        rd_b(0, 1'b1, 'h205, "R4 shared pending OR", 8'h01);
        wr_b(1, 1'b1, 'h285, 8'h01);
        rd_b(0, 1'b1, 'h205, "R4 shared pending clear", 8'h00);
        wr_b(0, 1'b1, 'h305, 8'h01);
        rd_b(1, 1'b1, 'h305, "R5 shared active", 8'h01);
        wr_b(0, 1'b1, 'h385, 8'h01);
        rd_b(1, 1'b1, 'h305, "R5 active clear", 8'h00);

        // configuration
        wr_b(0, 1'b1, 'hC00, 8'h00);
        rd_b(0, 1'b1, 'hC00, "R8 SGI forced edge", 8'hAA);
        wr_b(0, 1'b1, 'hC08, 8'h55);
        rd_b(0, 1'b1, 'hC08, "R8 shared cfg", 8'h55);

        // unmapped
        wr_b(0, 1'b1, 'h400, 8'hFF);
        rd_b(0, 1'b1, 'h400, "R13 unmapped", 8'h00);
        rd_b(1, 1'b1, 'hF30, "R13 past SGI window", 8'h00);

        // randomized traffic against the reference model
        for (int i = 0; i < 3000; i++) begin
            bit [7:0] g;
            if ($urandom_range(0, 39) == 0) sec_ext_en = ~sec_ext_en;
            access(1'($urandom_range(0, 1)), int'($urandom_range(0, NCPU - 1)),
                   ($urandom_range(0, 2) == 0), rand_addr(), 8'($urandom), g);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule